// File: doc/BRIEF.md
# Machine-Mode Interrupt Trap Controller

This block keeps the machine-level interrupt state of a single hardware thread. Alongside the registers it sequences interrupt entry and return. A core reads and writes the registers through a simple CSR port. Three level inputs bring in the machine software, timer and external interrupt lines. A current-PC input and a current-privilege input supply the state that is saved when an interrupt is taken.

Each cycle the block combines the pending and enable registers and picks one source by a fixed priority order. If the global machine enable is set, it raises a trap request together with the handler address. On the next clock edge it records the entry state. An MRET strobe restores the enable and hands back the saved return PC and privilege.

Top module: `irq_trap_ctrl`

## Requirements
- R1: After reset every register reads zero, except the status register, which reads 0x1800 (previous-privilege field at bits 12:11 equal to 3).
- R2: Register addresses are status 0x300, enable 0x304, vector 0x305, return PC 0x341, cause 0x342 and pending 0x344. In the status register only bits 1, 3, 5, 7, 8 and 12:11 can be written, so writing all ones reads back 0x19AA. Bit 3 is the global enable and bit 7 the previous enable.
- R3: The enable register keeps only bits 1, 3, 5, 7, 9 and 11 (mask 0xAAA). In the pending register, bits 1, 5 and 9 are written by software. Bits 3, 7 and 11 follow the software, timer and external input lines and ignore writes. All other bits read zero.
- R4: A trap is requested in the same cycle exactly when status bit 3 is set and pending AND enable is non-zero.
- R5: Among pending and enabled sources, the winner is chosen in this order, highest first: code 11, 3, 7, 9, 1, 5.
- R6: On the clock edge of a trap, bit 7 takes the old bit 3 and bit 3 clears. Bits 12:11 take the current privilege, the return-PC register takes the current PC, and the cause register takes bit 63 set plus the winning code.
- R7: When vector bits 1:0 equal 0, the handler address is the vector with bits 1:0 cleared. When they equal 1, it is that base plus four times the code.
- R8: A write to the vector register always stores bits 63:2. It stores bits 1:0 only when the written value is 0 or 1, and keeps the old mode otherwise.
- R9: The return PC output shows the return-PC register and the return privilege output shows bits 12:11. On an MRET strobe, bit 3 takes bit 7 and bit 7 is set, while bits 12:11 stay unchanged.
- R10: A trap overrides an MRET strobe and a CSR write to the status, return-PC or cause register in the same cycle. An MRET overrides a status write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data, combinational |
| msw_irq_i | input | 1 | Machine software interrupt line |
| mtimer_irq_i | input | 1 | Machine timer interrupt line |
| mext_irq_i | input | 1 | Machine external interrupt line |
| cur_pc_i | input | 64 | PC to save on entry |
| cur_priv_i | input | 2 | Privilege to save on entry |
| mret_i | input | 1 | Return-from-handler strobe |
| trap_o | output | 1 | Interrupt trap request |
| trap_pc_o | output | 64 | Handler address |
| ret_pc_o | output | 64 | Return PC |
| ret_priv_o | output | 2 | Return privilege |

## Verification
A wrong enable or pending bit appears at once on trap_o, or as a wrong vectored address on trap_pc_o in the same cycle. A corrupted entry update shows one cycle later, through status, return-PC and cause readback and through ret_pc_o and ret_priv_o. Because the bench model is compared on every cycle, a priority or mode error is caught on the first cycle it affects.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
    localparam int CSR_W   = 64;
    localparam int ADDR_W  = 12;
    localparam int CODE_W  = 4;
    localparam int NUM_SRC = 6;

    localparam logic [ADDR_W-1:0] A_STATUS = 12'h300;
    localparam logic [ADDR_W-1:0] A_IE     = 12'h304;
    localparam logic [ADDR_W-1:0] A_TVEC   = 12'h305;
    localparam logic [ADDR_W-1:0] A_EPC    = 12'h341;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 12'h342;
    localparam logic [ADDR_W-1:0] A_IP     = 12'h344;

    localparam int B_GIE  = 3;
    localparam int B_PGIE = 7;
    localparam int B_PPL  = 11;

    localparam logic [CSR_W-1:0] STATUS_WMASK = 64'h19AA;
    localparam logic [CSR_W-1:0] IE_MASK      = 64'hAAA;
    localparam logic [CSR_W-1:0] SWP_MASK     = 64'h222;
    localparam logic [CSR_W-1:0] STATUS_RST   = 64'h1800;
    localparam logic [1:0]       MODE_VEC     = 2'd1;

    typedef struct packed {
        logic [CSR_W-1:0] status;
        logic [CSR_W-1:0] ie;
        logic [CSR_W-1:0] swpend;
        logic [CSR_W-1:0] tvec;
        logic [CSR_W-1:0] epc;
        logic [CSR_W-1:0] cause;
    } csr_state_t;

    function automatic logic [CODE_W-1:0] rank_code(input int rank);
        case (rank)
            0:       rank_code = 4'd11;
            1:       rank_code = 4'd3;
            2:       rank_code = 4'd7;
            3:       rank_code = 4'd9;
            4:       rank_code = 4'd1;
            default: rank_code = 4'd5;
        endcase
    endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_trap_pkg::*;
(
    input  logic [CSR_W-1:0]  active_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);
    always_comb begin
        valid_o = 1'b0;
        code_o  = '0;
        for (int r = NUM_SRC - 1; r >= 0; r--) begin
            if (active_i[rank_code(r)]) begin
                valid_o = 1'b1;
                code_o  = rank_code(r);
            end
        end
    end
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc
    import irq_trap_pkg::*;
(
    input  logic [CSR_W-1:0]  tvec_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CSR_W-1:0]  target_o
);
    localparam int PAD_W = CSR_W - CODE_W - 2;

    logic [CSR_W-1:0] base;
    logic [CSR_W-1:0] offset;

    always_comb begin
        base   = {tvec_i[CSR_W-1:2], 2'b00};
        offset = (tvec_i[1:0] == MODE_VEC) ? {{PAD_W{1'b0}}, code_i, 2'b00} : '0;
        target_o = base + offset;
    end
endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl
    import irq_trap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [CSR_W-1:0]  csr_wdata_i,
    output logic [CSR_W-1:0]  csr_rdata_o,
    input  logic              msw_irq_i,
    input  logic              mtimer_irq_i,
    input  logic              mext_irq_i,
    input  logic [CSR_W-1:0]  cur_pc_i,
    input  logic [1:0]        cur_priv_i,
    input  logic              mret_i,
    output logic              trap_o,
    output logic [CSR_W-1:0]  trap_pc_o,
    output logic [CSR_W-1:0]  ret_pc_o,
    output logic [1:0]        ret_priv_o
);
    localparam int CPAD_W = CSR_W - 1 - CODE_W;

    csr_state_t st_d, st_q;

    logic [CSR_W-1:0]  pend;
    logic [CSR_W-1:0]  active;
    logic              pick_valid;
    logic [CODE_W-1:0] pick_code;
    logic [CSR_W-1:0]  target;
    logic              take;

    // hardware pending lines sit at bits 3, 7, 11
    always_comb begin
        pend     = st_q.swpend & SWP_MASK;
        pend[3]  = msw_irq_i;
        pend[7]  = mtimer_irq_i;
        pend[11] = mext_irq_i;
        active   = pend & st_q.ie;
    end

    irq_pick u_pick (
        .active_i (active),
        .valid_o  (pick_valid),
        .code_o   (pick_code)
    );

    irq_vec_calc u_vec (
        .tvec_i   (st_q.tvec),
        .code_i   (pick_code),
        .target_o (target)
    );

    assign take       = st_q.status[B_GIE] & pick_valid;
    assign trap_o     = take;
    assign trap_pc_o  = target;
    assign ret_pc_o   = st_q.epc;
    assign ret_priv_o = st_q.status[B_PPL+1:B_PPL];

    always_comb begin
        case (csr_addr_i)
            A_STATUS: csr_rdata_o = st_q.status;
            A_IE:     csr_rdata_o = st_q.ie;
            A_IP:     csr_rdata_o = pend;
            A_TVEC:   csr_rdata_o = st_q.tvec;
            A_EPC:    csr_rdata_o = st_q.epc;
            A_CAUSE:  csr_rdata_o = st_q.cause;
            default:  csr_rdata_o = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (csr_we_i) begin
            case (csr_addr_i)
                A_STATUS: st_d.status = csr_wdata_i & STATUS_WMASK;
                A_IE:     st_d.ie     = csr_wdata_i & IE_MASK;
                A_IP:     st_d.swpend = csr_wdata_i & SWP_MASK;
                A_TVEC: begin
                    st_d.tvec[CSR_W-1:2] = csr_wdata_i[CSR_W-1:2];
                    if (csr_wdata_i[1] == 1'b0) begin
                        st_d.tvec[1:0] = csr_wdata_i[1:0];
                    end
                end
                A_EPC:    st_d.epc    = csr_wdata_i;
                A_CAUSE:  st_d.cause  = csr_wdata_i;
                default:  ;
            endcase
        end
        if (mret_i) begin
            st_d.status         = st_q.status;
            st_d.status[B_GIE]  = st_q.status[B_PGIE];
            st_d.status[B_PGIE] = 1'b1;
        end
        if (take) begin
            st_d.status                  = st_q.status;
            st_d.status[B_PGIE]          = st_q.status[B_GIE];
            st_d.status[B_GIE]           = 1'b0;
            st_d.status[B_PPL+1:B_PPL]   = cur_priv_i;
            st_d.epc                     = cur_pc_i;
            st_d.cause                   = {1'b1, {CPAD_W{1'b0}}, pick_code};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.status <= STATUS_RST;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irq_trap_chk.sv
module irq_trap_chk
    import irq_trap_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              trap_i,
    input logic              mret_i,
    input logic              mext_i,
    input logic [CSR_W-1:0]  cur_pc_i,
    input logic [1:0]        cur_priv_i,
    input logic [CODE_W-1:0] code_i,
    input csr_state_t        st_i
);
    a_r4_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_i.status[B_GIE] |-> !trap_i);

    a_r5_ext_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_i && mext_i && st_i.ie[11]) |-> (code_i == 4'd11));

    a_r6_entry_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (st_i.epc == $past(cur_pc_i)) && !st_i.status[B_GIE]
                   && st_i.status[B_PGIE]
                   && (st_i.status[B_PPL+1:B_PPL] == $past(cur_priv_i))
                   && st_i.cause[CSR_W-1]
                   && (st_i.cause[CODE_W-1:0] == $past(code_i)));

    a_r8_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_i.tvec[1] == 1'b0);

    a_r9_return_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mret_i && !trap_i) |=> (st_i.status[B_GIE] == $past(st_i.status[B_PGIE]))
                                && st_i.status[B_PGIE]);
endmodule

bind irq_trap_ctrl irq_trap_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trap_i     (trap_o),
    .mret_i     (mret_i),
    .mext_i     (mext_irq_i),
    .cur_pc_i   (cur_pc_i),
    .cur_priv_i (cur_priv_i),
    .code_i     (pick_code),
    .st_i       (st_q)
);

// File: tb/irq_trap_ctrl_tb.sv
module irq_trap_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = 12'h300;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        msw = 1'b0, mtm = 1'b0, mex = 1'b0;
    logic [63:0] pc = '0;
    logic [1:0]  priv = 2'd3;
    logic        mret = 1'b0;
    logic        trap;
    logic [63:0] trap_pc, ret_pc;
    logic [1:0]  ret_priv;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_st, m_ie, m_sw, m_tv, m_epc, m_cause;
    int          order[6] = '{11, 3, 7, 9, 1, 5};

    always #10 clk = ~clk;

    irq_trap_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
        .csr_wdata_i(wdata), .csr_rdata_o(rdata), .msw_irq_i(msw),
        .mtimer_irq_i(mtm), .mext_irq_i(mex), .cur_pc_i(pc), .cur_priv_i(priv),
        .mret_i(mret), .trap_o(trap), .trap_pc_o(trap_pc), .ret_pc_o(ret_pc),
        .ret_priv_o(ret_priv)
    );

    function automatic logic [63:0] m_pend();
        logic [63:0] p = m_sw;
        p[3]  = msw;
        p[7]  = mtm;
        p[11] = mex;
        return p;
    endfunction

    function automatic int m_code();
        logic [63:0] a = m_pend() & m_ie;
        foreach (order[i]) if (a[order[i]]) return order[i];
        return -1;
    endfunction

    function automatic logic m_take();
        return m_st[3] && (m_code() >= 0);
    endfunction

    function automatic logic [63:0] m_target();
        logic [63:0] b = m_tv & ~64'h3;
        if (m_tv[1:0] == 2'd1) b = b + 64'(4 * m_code());
        return b;
    endfunction

    function automatic logic [63:0] m_read();
        case (addr)
            12'h300: return m_st;
            12'h304: return m_ie;
            12'h344: return m_pend();
            12'h305: return m_tv;
            12'h341: return m_epc;
            12'h342: return m_cause;
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic m_update();
        logic        tk = m_take();
        int          c  = m_code();
        logic [63:0] old = m_st;
        if (we) begin
            if (addr == 12'h304) m_ie = wdata & 64'hAAA;
            if (addr == 12'h344) m_sw = wdata & 64'h222;
            if (addr == 12'h305) begin
                m_tv = {wdata[63:2], (wdata[1:0] < 2) ? wdata[1:0] : m_tv[1:0]};
            end
            if (!tk) begin
                if (addr == 12'h341) m_epc = wdata;
                if (addr == 12'h342) m_cause = wdata;
                if (addr == 12'h300 && !mret) m_st = wdata & 64'h19AA;
            end
        end
        if (tk) begin
            m_st        = old;
            m_st[7]     = old[3];
            m_st[3]     = 1'b0;
            m_st[12:11] = priv;
            m_epc       = pc;
            m_cause     = (64'h1 << 63) | 64'(c);
        end else if (mret) begin
            m_st    = old;
            m_st[3] = old[7];
            m_st[7] = 1'b1;
        end
    endtask

    // one clock: compare at mid-low phase, then advance model at the edge
    task automatic cyc(input string tag);
        logic exp_t;
        #1;
        exp_t = m_take();
        check(tag, "rdata", rdata, m_read());
        check(tag, "trap", {63'h0, trap}, {63'h0, exp_t});
        if (exp_t) check(tag, "trap_pc", trap_pc, m_target());
        check(tag, "ret_pc", ret_pc, m_epc);
        check(tag, "ret_priv", {62'h0, ret_priv}, {62'h0, m_st[12:11]});
        @(posedge clk);
        m_update();
        @(negedge clk);
        we   = 1'b0;
        mret = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input string tag);
        we = 1'b1; addr = a; wdata = d;
        cyc(tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        addr = a;
        cyc(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_st = 64'h1800; m_ie = '0; m_sw = '0; m_tv = '0; m_epc = '0; m_cause = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(12'h300, "R1"); rd(12'h304, "R1"); rd(12'h344, "R1");
        rd(12'h305, "R1"); rd(12'h341, "R1"); rd(12'h342, "R1");
        // R2 status write mask
        wr(12'h300, '1, "R2"); rd(12'h300, "R2");
        wr(12'h300, '0, "R2"); rd(12'h123, "R2");
        // R3 enable and pending masks
        wr(12'h304, '1, "R3"); rd(12'h304, "R3");
        wr(12'h344, '1, "R3"); rd(12'h344, "R3");
        msw = 1'b1; rd(12'h344, "R3");
        msw = 1'b0; wr(12'h344, '0, "R3"); rd(12'h344, "R3");
        // R8 mode retention
        wr(12'h305, 64'h1002, "R8"); rd(12'h305, "R8");
        wr(12'h305, 64'h1001, "R8"); rd(12'h305, "R8");
        wr(12'h305, 64'h2003, "R8"); rd(12'h305, "R8");
        // R4 gating: pending enabled but global enable off
        mtm = 1'b1; rd(12'h300, "R4");
        wr(12'h304, 64'h0, "R4"); wr(12'h300, 64'h8, "R4"); rd(12'h300, "R4");
        wr(12'h300, 64'h0, "R4");
        wr(12'h304, 64'hAAA, "R4");
        // R6 R7 vectored timer entry from user level
        priv = 2'd0; pc = 64'h8000_0040;
        wr(12'h300, 64'h8, "R7");
        rd(12'h300, "R6"); rd(12'h341, "R6"); rd(12'h342, "R6");
        // R9 return
        mtm = 1'b0; mret = 1'b1; rd(12'h300, "R9");
        rd(12'h300, "R9");
        // R5 priority chain
        wr(12'h300, 64'h0, "R5");
        wr(12'h344, 64'h222, "R5"); msw = 1'b1; mtm = 1'b1; mex = 1'b1;
        priv = 2'd1; pc = 64'h400;
        for (int k = 0; k < 6; k++) begin
            wr(12'h300, 64'h8, "R5");
            rd(12'h342, "R5");
            case (k)
                0: mex = 1'b0;
                1: msw = 1'b0;
                2: mtm = 1'b0;
                3: wr(12'h344, 64'h022, "R5");
                4: wr(12'h344, 64'h020, "R5");
                default: wr(12'h344, 64'h000, "R5");
            endcase
        end
        // R7 direct mode
        wr(12'h305, 64'h3000, "R7");
        mex = 1'b1; wr(12'h300, 64'h8, "R7"); rd(12'h341, "R7");
        mex = 1'b0;
        // R10 trap beats MRET and status/epc writes
        wr(12'h300, 64'h8, "R10");
        mtm = 1'b1; pc = 64'hABC0; mret = 1'b1; we = 1'b1; addr = 12'h300; wdata = '0;
        cyc("R10");
        mtm = 1'b0; rd(12'h300, "R10"); rd(12'h341, "R10");
        // R10 MRET beats status write
        mret = 1'b1; we = 1'b1; addr = 12'h300; wdata = 64'h1800;
        cyc("R10");
        rd(12'h300, "R10");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule